// File: doc/BRIEF.md
# Dual-Line Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and presents them to a processor on two separate outputs: a normal interrupt line and a fast interrupt line. Every input line is sampled into a raw level register that tracks the line level. No edge is captured and nothing is held. Two independent enable masks, one per output, select which raw levels reach each line. An output is high while at least one enabled raw level is high.

Software reaches the block through a simple word-addressed register port with a one-cycle read latency. Each mask has one address where ones in the write data set mask bits and a second address where ones clear them. Neither mask is ever overwritten in full. Source 0 also has a software contribution, which is set and cleared through two more addresses. It is ORed with the hardware line 0, so clearing it never hides a hardware request. Priority, vectoring and edge detection are left to the software that services the lines.

Top module: `intc_dual_line`

## Requirements
- R1: After synchronous reset both enable masks and the software bit are zero. `irq_o` and `fiq_o` are low, and `rdata` is zero.
- R2: Reading word 1 or word 9 returns the raw levels. Bit n is `src_i[n]` OR'd with the software bit (bit 0 only). A line that drops is shown low again, with no latching.
- R3: A write to word 2 ORs `wdata` into the normal mask. A write to word 10 ORs it into the fast mask. Word 2 reads back the normal mask and word 10 reads back the fast mask.
- R4: A write to word 3 clears the normal-mask bits that are one in `wdata`. A write to word 11 does the same for the fast mask. Bits written as zero are kept.
- R5: `irq_o` is a register. It is high exactly when (raw AND normal mask) is non-zero, and it follows a change on `src_i` or a mask write at the next clock edge.
- R6: `fiq_o` is a register. It is high exactly when (raw AND fast mask) is non-zero, with the same one-edge timing. It is independent of the normal mask.
- R7: Word 0 reads (raw AND normal mask). Word 8 reads (raw AND fast mask).
- R8: A write to word 4 with `wdata[0]`=1 sets the software bit, and a write to word 5 with `wdata[0]`=1 clears it. A write to either word with `wdata[0]`=0 leaves it unchanged. Word 4 reads raw bit 0 in bit 0, with all other bits zero.
- R9: Clearing the software bit removes only the software contribution. Raw bit 0 stays high while `src_i[0]` is high.
- R10: Reads of words 3, 5 and 11, and of any unused word, return zero. Writes to words 0, 1, 8 and 9 change no state.
- R11: `rdata` carries the value selected by a read one clock edge after `rd_en` is sampled, and it is zero after an edge at which no read was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC (32) | Level interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (6) | Word offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Every result in this block is due one clock edge after its cause. Both interrupt outputs respond at the edge that samples a source change or a mask write. The raw and mask registers change at that same edge. Read data appears at the edge that samples `rd_en`, and it shows the register state from before that edge. The bench drives all stimulus on the falling edge and samples on the next falling edge, so each output check falls exactly one rising edge after its stimulus. A read is issued only after the write or source change it observes has passed at least one rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word offsets of the register port. Their values are fixed by software.
  localparam int OFF_IRQ_MSK_STAT = 0;
  localparam int OFF_RAW_A        = 1;
  localparam int OFF_IRQ_EN_SET   = 2;
  localparam int OFF_IRQ_EN_CLR   = 3;
  localparam int OFF_SOFT_SET     = 4;
  localparam int OFF_SOFT_CLR     = 5;
  localparam int OFF_FIQ_MSK_STAT = 8;
  localparam int OFF_RAW_B        = 9;
  localparam int OFF_FIQ_EN_SET   = 10;
  localparam int OFF_FIQ_EN_CLR   = 11;

  // Index of each output line in the per-line arrays.
  localparam int LINE_IRQ = 0;
  localparam int LINE_FIQ = 1;
  localparam int NUM_LINES = 2;

endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] data,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_next
);

  always_comb begin
    mask_next = mask_q;
    if (set_stb) mask_next = mask_q | data;
    else if (clr_stb) mask_next = mask_q & ~data;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_next;
  end

  // R3: every bit written to the set address is on after the edge
  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((mask_q & $past(data)) == $past(data)));

  // R4: every bit written to the clear address is off after the edge
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((mask_q & $past(data)) == '0));

  // R4: bits written as zero to the clear address are kept
  p_clr_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((mask_q & ~$past(data)) == ($past(mask_q) & ~$past(data))));

endmodule

// File: rtl/intc_raw_level.sv
module intc_raw_level #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               soft_set,
  input  logic               soft_clr,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] raw_next
);

  logic soft_q;
  logic soft_next;

  always_comb begin
    soft_next = soft_q;
    if (soft_set) soft_next = 1'b1;
    else if (soft_clr) soft_next = 1'b0;
  end

  // The software bit only adds to source 0. It never masks the hardware line.
  always_comb begin
    raw_next    = src_i;
    raw_next[0] = src_i[0] | soft_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      soft_q <= soft_next;
      raw_q  <= raw_next;
    end
  end

  // R8: a soft set raises raw bit 0 at the next edge
  p_soft_set_r8: assert property (@(posedge clk) disable iff (rst)
    soft_set |=> raw_q[0]);

  // R9: hardware line 0 keeps raw bit 0 high even during a soft clear
  p_hw0_wins_r9: assert property (@(posedge clk) disable iff (rst)
    src_i[0] |=> raw_q[0]);

  // R2: a line that is low and has no soft contribution shows low
  p_no_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (!src_i[NUM_SRC-1]) |=> !raw_q[NUM_SRC-1]);

endmodule

// File: rtl/intc_reg_if.sv
module intc_reg_if
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_SRC-1:0]   raw_q,
  input  logic [NUM_SRC-1:0]   irq_mask_q,
  input  logic [NUM_SRC-1:0]   fiq_mask_q,
  output logic [NUM_LINES-1:0] en_set,
  output logic [NUM_LINES-1:0] en_clr,
  output logic                 soft_set,
  output logic                 soft_clr,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [ADDR_W-1:0] A_IRQ_STAT = ADDR_W'(OFF_IRQ_MSK_STAT);
  localparam logic [ADDR_W-1:0] A_RAW_A    = ADDR_W'(OFF_RAW_A);
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = ADDR_W'(OFF_IRQ_EN_SET);
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = ADDR_W'(OFF_IRQ_EN_CLR);
  localparam logic [ADDR_W-1:0] A_SOFT_SET = ADDR_W'(OFF_SOFT_SET);
  localparam logic [ADDR_W-1:0] A_SOFT_CLR = ADDR_W'(OFF_SOFT_CLR);
  localparam logic [ADDR_W-1:0] A_FIQ_STAT = ADDR_W'(OFF_FIQ_MSK_STAT);
  localparam logic [ADDR_W-1:0] A_RAW_B    = ADDR_W'(OFF_RAW_B);
  localparam logic [ADDR_W-1:0] A_FIQ_SET  = ADDR_W'(OFF_FIQ_EN_SET);
  localparam logic [ADDR_W-1:0] A_FIQ_CLR  = ADDR_W'(OFF_FIQ_EN_CLR);

  // Write decode. Status words have no write strobe, so writes there do nothing.
  always_comb begin
    en_set = '0;
    en_clr = '0;
    en_set[LINE_IRQ] = wr_en && (addr == A_IRQ_SET);
    en_clr[LINE_IRQ] = wr_en && (addr == A_IRQ_CLR);
    en_set[LINE_FIQ] = wr_en && (addr == A_FIQ_SET);
    en_clr[LINE_FIQ] = wr_en && (addr == A_FIQ_CLR);
    soft_set = wr_en && (addr == A_SOFT_SET) && wdata[0];
    soft_clr = wr_en && (addr == A_SOFT_CLR) && wdata[0];
  end

  // Read selection. Clear-only and unused words read as zero.
  logic [NUM_SRC-1:0] rd_sel;

  always_comb begin
    case (addr)
      A_IRQ_STAT:       rd_sel = raw_q & irq_mask_q;
      A_RAW_A, A_RAW_B: rd_sel = raw_q;
      A_IRQ_SET:        rd_sel = irq_mask_q;
      A_SOFT_SET:       rd_sel = {{(NUM_SRC-1){1'b0}}, raw_q[0]};
      A_FIQ_STAT:       rd_sel = raw_q & fiq_mask_q;
      A_FIQ_SET:        rd_sel = fiq_mask_q;
      default:          rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= DATA_W'(rd_sel);
    else            rdata <= '0;
  end

  // R10: clear-only words read as zero
  p_clr_word_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == A_IRQ_CLR || addr == A_SOFT_CLR || addr == A_FIQ_CLR)) |=> (rdata == '0));

  // R11: no read sampled means zero read data
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

endmodule

// File: rtl/intc_dual_line.sv
module intc_dual_line
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  logic [NUM_LINES-1:0] en_set;
  logic [NUM_LINES-1:0] en_clr;
  logic                 soft_set;
  logic                 soft_clr;
  logic [NUM_SRC-1:0]   raw_q;
  logic [NUM_SRC-1:0]   raw_next;
  logic [NUM_SRC-1:0]   mask_q    [NUM_LINES];
  logic [NUM_SRC-1:0]   mask_next [NUM_LINES];
  logic [NUM_LINES-1:0] line_q;

  intc_reg_if #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .raw_q      (raw_q),
    .irq_mask_q (mask_q[LINE_IRQ]),
    .fiq_mask_q (mask_q[LINE_FIQ]),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .soft_set   (soft_set),
    .soft_clr   (soft_clr),
    .rdata      (rdata)
  );

  intc_raw_level #(.NUM_SRC(NUM_SRC)) u_raw (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .soft_set (soft_set),
    .soft_clr (soft_clr),
    .raw_q    (raw_q),
    .raw_next (raw_next)
  );

  // One mask and one registered output per line
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    intc_mask_reg #(.W(NUM_SRC)) u_mask (
      .clk       (clk),
      .rst       (rst),
      .set_stb   (en_set[k]),
      .clr_stb   (en_clr[k]),
      .data      (wdata[NUM_SRC-1:0]),
      .mask_q    (mask_q[k]),
      .mask_next (mask_next[k])
    );

    always_ff @(posedge clk) begin
      if (rst) line_q[k] <= 1'b0;
      else     line_q[k] <= |(raw_next & mask_next[k]);
    end
  end

  assign irq_o = line_q[LINE_IRQ];
  assign fiq_o = line_q[LINE_FIQ];

  // R5: normal line agrees with the raw and mask registers
  p_irq_line_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw_q & mask_q[LINE_IRQ]));

  // R6: fast line agrees with the raw and mask registers
  p_fiq_line_r6: assert property (@(posedge clk) disable iff (rst)
    fiq_o == |(raw_q & mask_q[LINE_FIQ]));

  // R1: both lines are low right after reset is released
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!irq_o && !fiq_o));

endmodule

// File: tb/intc_dual_line_tb.sv
module intc_dual_line_tb_top;

  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic            irq_o;
  logic            fiq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  intc_dual_line #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // The write is sampled at the rising edge between two falling edges
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // rdata is sampled at the falling edge after the edge that took rd_en
  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_src(input logic [NSRC-1:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 rdata", rdata, 0);
    rd(2, d);  check("R1 irq mask", d, 0);
    rd(10, d); check("R1 fiq mask", d, 0);
    rd(4, d);  check("R1 soft bit", d, 0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    set_src(32'hA500_0F02);
    rd(1, d); check("R2 raw word1", d, 32'hA500_0F02);
    rd(9, d); check("R2 raw word9", d, 32'hA500_0F02);
    set_src(32'h0000_0F00);
    rd(1, d); check("R2 raw follows drop", d, 32'h0000_0F00);
    check("R5 no mask no irq", 32'(irq_o), 0);
    set_src('0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    wr(2, 32'h0000_00F0);
    wr(2, 32'h8000_0001);
    rd(2, d); check("R3 irq set ors", d, 32'h8000_00F1);
    wr(10, 32'h0000_0300);
    rd(10, d); check("R3 fiq set", d, 32'h0000_0300);
    wr(3, 32'h0000_0030);
    rd(2, d); check("R4 irq clr", d, 32'h8000_00C1);
    wr(11, 32'h0000_0100);
    rd(10, d); check("R4 fiq clr", d, 32'h0000_0200);
    rd(3, d);  check("R10 read word3", d, 0);
    rd(11, d); check("R10 read word11", d, 0);
  endtask

  task automatic t_lines();
    logic [31:0] d;
    // irq mask 8000_00C1, fiq mask 0000_0200
    @(negedge clk); src_i = 32'h0000_0040;
    @(negedge clk);
    check("R5 irq rises one edge", 32'(irq_o), 1);
    check("R6 fiq stays low", 32'(fiq_o), 0);
    rd(0, d); check("R7 irq masked stat", d, 32'h0000_0040);
    @(negedge clk); src_i = 32'h0000_0200;
    @(negedge clk);
    check("R5 irq falls", 32'(irq_o), 0);
    check("R6 fiq rises", 32'(fiq_o), 1);
    rd(8, d); check("R7 fiq masked stat", d, 32'h0000_0200);
    // a mask clear drops the line at the edge of the write
    @(negedge clk); wr_en = 1'b1; addr = AW'(11); wdata = 32'h0000_0200;
    @(negedge clk); wr_en = 1'b0;
    check("R6 fiq falls on clr", 32'(fiq_o), 0);
    // a mask set raises the line at the edge of the write
    @(negedge clk); wr_en = 1'b1; addr = AW'(2); wdata = 32'h0000_0200;
    @(negedge clk); wr_en = 1'b0;
    check("R5 irq rises on set", 32'(irq_o), 1);
    check("R6 fiq independent", 32'(fiq_o), 0);
    set_src('0);
    check("R5 irq low again", 32'(irq_o), 0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(4, 32'hFFFF_FFFE);
    rd(4, d); check("R8 bit0 zero ignored", d, 0);
    wr(4, 32'h0000_0001);
    rd(4, d); check("R8 soft set", d, 1);
    rd(1, d); check("R8 raw bit0", d, 1);
    check("R5 soft drives irq", 32'(irq_o), 1);
    wr(5, 32'h0000_0002);
    rd(4, d); check("R8 clr bit0 zero ignored", d, 1);
    set_src(32'h0000_0001);
    wr(5, 32'h0000_0001);
    rd(4, d); check("R9 hw0 holds bit0", d, 1);
    set_src('0);
    rd(4, d); check("R9 soft gone after hw drop", d, 0);
    check("R5 irq off", 32'(irq_o), 0);
  endtask

  task automatic t_status_writes();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    rd(2, d);  check("R10 irq mask unchanged", d, 32'h8000_02C1);
    rd(10, d); check("R10 fiq mask unchanged", d, 0);
    rd(1, d);  check("R10 raw unchanged", d, 0);
    rd(5, d);  check("R10 read word5", d, 0);
    rd(7, d);  check("R10 read unused", d, 0);
  endtask

  task automatic t_latency();
    set_src(32'h0000_0080);
    @(negedge clk); rd_en = 1'b1; addr = AW'(1);
    check("R11 rdata zero before edge", rdata, 0);
    @(negedge clk); rd_en = 1'b0;
    check("R11 rdata after edge", rdata, 32'h0000_0080);
    @(negedge clk);
    check("R11 rdata zero when idle", rdata, 0);
    set_src('0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_raw();
    t_masks();
    t_lines();
    t_soft();
    t_status_writes();
    t_latency();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule